// File: doc/BRIEF.md
# Time-Multiplexed Weighted Score Unit

This block forms a weighted total of four unsigned scores with only one adder and one multiplier. A pulse on `start` captures the four scores. A small controller then runs the datapath one operation per cycle: it adds the first three scores, scales that sum once by a fixed one-fifth weight and parks the product in a scratch register. It then scales the fourth score by a fixed two-fifths weight, adds the two products and rounds the total. The integer result is registered and flagged by a one-cycle `done` pulse.

Both weights are fixed-point constants with `FRAC_W` fractional bits. Each is derived from its ratio and rounded to the nearest step. The block needs more cycles than a fully parallel tree would. In return it carries a single arithmetic unit of each kind, plus operand multiplexers, an accumulator and a scratch register.

Top module: `ws_score_unit`

## Requirements
- R1: While `rst` is high, and after it is released until a job finishes, `result` is 0 and `done` is 0.
- R2: With the default parameters, `result` equals floor((51·(a+b+c) + 102·d + 128) / 256), where a, b, c and d are the captured `score_a`..`score_d`. The weight 51 is round(0.2·256), the weight 102 is round(0.4·256), and the rounding is half-up.
- R3: `done` is high for exactly one cycle. It rises on the 8th rising edge when the edge that samples `start` high in the idle state is counted as the first. It is low between those two edges.
- R4: The scores are captured on the edge that accepts `start`. Later changes on the score inputs do not affect that job's result.
- R5: A `start` seen while a job is in progress is ignored: it does not restart the job, does not change its result and produces no extra `done` pulse.
- R6: `result` keeps its value between `done` pulses, whatever the inputs do.
- R7: In any cycle at most one of the shared adder and the shared multiplier produces a value that is stored.
- R8: A `start` that is high in the cycle where `done` is high is accepted, so jobs can run back to back every 8 cycles.
- R9: Full-scale scores (all 255) give 254, and no intermediate sum loses a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture scores and begin a job (used only when idle) |
| score_a | input | SCORE_W | First score, weight one fifth |
| score_b | input | SCORE_W | Second score, weight one fifth |
| score_c | input | SCORE_W | Third score, weight one fifth |
| score_d | input | SCORE_W | Fourth score, weight two fifths |
| result | output | SCORE_W+WEIGHT_W+3-FRAC_W | Rounded weighted total, registered |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The hardest condition to create from the ports is a second `start` that lands in the middle of a job while the score inputs are also moving. In that case only the captured operands and the unbroken step sequence protect the result. The stimulus raises `start` again during the busy window with different scores. It then checks the pulse timing, the first job's result and the absence of a second pulse. A sweep over a grid of score values, run back to back, covers the rounding boundaries and full scale.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADD_AB,
    S_ADD_C,
    S_MUL_SUM,
    S_MUL_D,
    S_ADD_PROD,
    S_ROUND,
    S_FIN
  } ws_state_e;

  typedef enum logic {
    ADD_A_SCORE,
    ADD_A_ACC
  } add_a_e;

  typedef enum logic [1:0] {
    ADD_B_SCORE_B,
    ADD_B_SCORE_C,
    ADD_B_SCRATCH,
    ADD_B_HALF
  } add_b_e;

  typedef enum logic {
    MUL_A_ACC,
    MUL_A_SCORE_D
  } mul_a_e;

  typedef enum logic {
    MUL_B_FIFTH,
    MUL_B_TWO_FIFTHS
  } mul_b_e;

  typedef struct packed {
    logic   latch;
    logic   add_en;
    logic   mul_en;
    logic   acc_we;
    logic   acc_from_mul;
    logic   scr_we;
    logic   fin;
    add_a_e add_a;
    add_b_e add_b;
    mul_a_e mul_a;
    mul_b_e mul_b;
  } ws_op_t;

  // Nearest fixed-point step of num/den with frac fractional bits
  function automatic int unsigned frac_weight(input int unsigned num,
                                              input int unsigned den,
                                              input int unsigned frac);
    return ((num << frac) + den / 2) / den;
  endfunction

endpackage

// File: rtl/ws_ctrl.sv
module ws_ctrl
  import ws_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output ws_op_t op
);

  ws_state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (start) nxt = S_ADD_AB;
      S_ADD_AB:   nxt = S_ADD_C;
      S_ADD_C:    nxt = S_MUL_SUM;
      S_MUL_SUM:  nxt = S_MUL_D;
      S_MUL_D:    nxt = S_ADD_PROD;
      S_ADD_PROD: nxt = S_ROUND;
      S_ROUND:    nxt = S_FIN;
      S_FIN:      nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_comb begin
    op = '{latch: 1'b0, add_en: 1'b0, mul_en: 1'b0, acc_we: 1'b0,
           acc_from_mul: 1'b0, scr_we: 1'b0, fin: 1'b0,
           add_a: ADD_A_ACC, add_b: ADD_B_SCORE_B,
           mul_a: MUL_A_ACC, mul_b: MUL_B_FIFTH};
    unique case (state)
      S_IDLE: op.latch = start;
      S_ADD_AB: begin
        op.add_en = 1'b1; op.acc_we = 1'b1;
        op.add_a  = ADD_A_SCORE; op.add_b = ADD_B_SCORE_B;
      end
      S_ADD_C: begin
        op.add_en = 1'b1; op.acc_we = 1'b1;
        op.add_a  = ADD_A_ACC; op.add_b = ADD_B_SCORE_C;
      end
      S_MUL_SUM: begin
        op.mul_en = 1'b1; op.scr_we = 1'b1;
        op.mul_a  = MUL_A_ACC; op.mul_b = MUL_B_FIFTH;
      end
      S_MUL_D: begin
        op.mul_en = 1'b1; op.acc_we = 1'b1; op.acc_from_mul = 1'b1;
        op.mul_a  = MUL_A_SCORE_D; op.mul_b = MUL_B_TWO_FIFTHS;
      end
      S_ADD_PROD: begin
        op.add_en = 1'b1; op.acc_we = 1'b1;
        op.add_a  = ADD_A_ACC; op.add_b = ADD_B_SCRATCH;
      end
      S_ROUND: begin
        op.add_en = 1'b1; op.acc_we = 1'b1;
        op.add_a  = ADD_A_ACC; op.add_b = ADD_B_HALF;
      end
      S_FIN:   op.fin = 1'b1;
      default: ;
    endcase
  end

  // R7: a single shared unit is active per cycle
  p_one_unit_r7: assert property (@(posedge clk) disable iff (rst)
    !(op.add_en && op.mul_en));

  // R5: a start during a job never re-enters the first step
  p_busy_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && start) |=> (state != S_ADD_AB));

  // R3: finishing step comes six steps after the first add
  p_step_count_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIN) |-> ($past(state, 6) == S_ADD_AB));

endmodule

// File: rtl/ws_adder.sv
module ws_adder #(
  parameter int W = 19
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);

  always_comb {carry, sum} = {1'b0, a} + {1'b0, b};

endmodule

// File: rtl/ws_mult.sv
module ws_mult #(
  parameter int AW = 10,
  parameter int BW = 8
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);

  always_comb p = {{BW{1'b0}}, a} * {{AW{1'b0}}, b};

endmodule

// File: rtl/ws_score_unit.sv
module ws_score_unit
  import ws_pkg::*;
#(
  parameter int SCORE_W  = 8,
  parameter int WEIGHT_W = 8,
  parameter int FRAC_W   = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [SCORE_W-1:0]                  score_a,
  input  logic [SCORE_W-1:0]                  score_b,
  input  logic [SCORE_W-1:0]                  score_c,
  input  logic [SCORE_W-1:0]                  score_d,
  output logic [SCORE_W+WEIGHT_W+3-FRAC_W-1:0] result,
  output logic                                done
);

  localparam int NUM_SC = 4;
  localparam int SUM_W  = SCORE_W + 2;
  localparam int PROD_W = SUM_W + WEIGHT_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int RES_W  = ACC_W - FRAC_W;
  localparam int unsigned W_FIFTH     = frac_weight(1, 5, FRAC_W);
  localparam int unsigned W_TWO_FIFTH = frac_weight(2, 5, FRAC_W);
  localparam logic [ACC_W-1:0] HALF   = ACC_W'(1) << (FRAC_W - 1);

  ws_op_t op;

  ws_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op    (op)
  );

  // Captured score bank
  logic [NUM_SC*SCORE_W-1:0] score_in, score_q;
  assign score_in = {score_d, score_c, score_b, score_a};

  for (genvar g = 0; g < NUM_SC; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)           score_q[g*SCORE_W +: SCORE_W] <= '0;
      else if (op.latch) score_q[g*SCORE_W +: SCORE_W] <= score_in[g*SCORE_W +: SCORE_W];
    end
  end

  logic [SCORE_W-1:0] sa, sb, sc, sd;
  assign sa = score_q[0*SCORE_W +: SCORE_W];
  assign sb = score_q[1*SCORE_W +: SCORE_W];
  assign sc = score_q[2*SCORE_W +: SCORE_W];
  assign sd = score_q[3*SCORE_W +: SCORE_W];

  logic [ACC_W-1:0] acc, scratch;

  // Shared adder operand muxes
  logic [ACC_W-1:0] add_a, add_b, add_sum;
  logic             add_carry;

  always_comb begin
    unique case (op.add_a)
      ADD_A_SCORE: add_a = ACC_W'(sa);
      default:     add_a = acc;
    endcase
    unique case (op.add_b)
      ADD_B_SCORE_B: add_b = ACC_W'(sb);
      ADD_B_SCORE_C: add_b = ACC_W'(sc);
      ADD_B_SCRATCH: add_b = scratch;
      default:       add_b = HALF;
    endcase
  end

  ws_adder #(.W(ACC_W)) u_add (
    .a     (add_a),
    .b     (add_b),
    .sum   (add_sum),
    .carry (add_carry)
  );

  // Shared multiplier operand muxes
  logic [SUM_W-1:0]    mul_a;
  logic [WEIGHT_W-1:0] mul_b;
  logic [PROD_W-1:0]   mul_p;

  always_comb begin
    unique case (op.mul_a)
      MUL_A_SCORE_D: mul_a = SUM_W'(sd);
      default:       mul_a = acc[SUM_W-1:0];
    endcase
    unique case (op.mul_b)
      MUL_B_TWO_FIFTHS: mul_b = WEIGHT_W'(W_TWO_FIFTH);
      default:          mul_b = WEIGHT_W'(W_FIFTH);
    endcase
  end

  ws_mult #(.AW(SUM_W), .BW(WEIGHT_W)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .p (mul_p)
  );

  // Accumulator and scratch
  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      scratch <= '0;
    end else begin
      if (op.acc_we) acc     <= op.acc_from_mul ? ACC_W'(mul_p) : add_sum;
      if (op.scr_we) scratch <= ACC_W'(mul_p);
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= op.fin;
      if (op.fin) result <= acc[ACC_W-1:FRAC_W];
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_scores_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !op.latch |=> $stable(score_q));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (op.acc_we && !op.acc_from_mul) |-> !add_carry);

  p_mul_fits_r9: assert property (@(posedge clk) disable iff (rst)
    (op.mul_en && op.mul_a == MUL_A_ACC) |-> (acc[ACC_W-1:SUM_W] == '0));

  initial begin
    assert (RES_W >= SCORE_W) else $error("result width too small");
  end

endmodule

// File: tb/ws_score_unit_bench.sv
module ws_score_unit_bench;

  localparam int SW = 8;
  localparam int RW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] sa = '0, sb = '0, sc = '0, sd = '0;
  logic [RW-1:0] result;
  logic          done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ws_score_unit u_ws_score_unit (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .score_a (sa),
    .score_b (sb),
    .score_c (sc),
    .score_d (sd),
    .result  (result),
    .done    (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_of(input int a, b, c, d);
    return (51 * (a + b + c) + 102 * d + 128) >> 8;
  endfunction

  // Called at a negedge; leaves at the negedge where done should be high.
  task automatic run_job(input int a, b, c, d, input bit poke, input string req);
    int exp;
    int early;
    exp = expect_of(a, b, c, d);
    sa = a[SW-1:0]; sb = b[SW-1:0]; sc = c[SW-1:0]; sd = d[SW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R3 pulse width", int'(done), 0);
    // R4: inputs move after capture
    sa = ~a[SW-1:0]; sb = ~b[SW-1:0]; sc = ~c[SW-1:0]; sd = ~d[SW-1:0];
    early = 0;
    for (int i = 0; i < 6; i++) begin
      if (poke && (i == 1 || i == 4)) start = 1'b1; // R5
      @(negedge clk);
      start = 1'b0;
      if (done) early++;
    end
    @(negedge clk);
    chk(done && early == 0, "R3 done timing", int'(done) + 2 * early, 1);
    chk(int'(result) == exp, req, int'(result), exp);
  endtask

  initial begin
    int s, d;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 in reset", int'(result) + int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 after reset", int'(result) + int'(done), 0);

    // R9 full scale
    run_job(255, 255, 255, 255, 1'b0, "R9 full scale");
    chk(result == 11'd254, "R9 value", int'(result), 254);
    @(negedge clk);
    chk(done == 1'b0, "R3 single cycle", int'(done), 0);

    run_job(0, 0, 0, 0, 1'b0, "R2 zeros");
    // R8: next job started in the done cycle
    run_job(1, 1, 0, 0, 1'b0, "R8 back-to-back");
    run_job(0, 0, 0, 1, 1'b0, "R2 single d");
    run_job(2, 0, 0, 0, 1'b0, "R2 rounding low");
    run_job(3, 0, 0, 0, 1'b0, "R2 rounding high");

    // R5: start pulses during busy window
    run_job(100, 50, 25, 200, 1'b1, "R5 busy start ignored");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R5 no extra done", int'(done), 0);
    end

    // R6: hold while idle with moving inputs
    s = int'(result);
    for (int i = 0; i < 6; i++) begin
      sa = SW'(i * 37); sb = SW'(i * 91); sd = SW'(i * 13);
      @(negedge clk);
      chk(int'(result) == s, "R6 result held", int'(result), s);
    end

    // Near-exhaustive grid sweep, back to back (R2, R4)
    for (int a = 0; a < 256; a += 51)
      for (int b = 0; b < 256; b += 51)
        for (int c = 0; c < 256; c += 51)
          for (int e = 0; e < 256; e += 51)
            run_job(a, b, c, e, 1'b0, "R2 grid");

    // Pseudo-random jobs with busy pokes (R4, R5)
    s = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
      d = s;
      run_job(d & 255, (d >> 8) & 255, (d >> 16) & 255, (d >> 24) & 255,
              i[0], "R4 captured operands");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule